// File: doc/BRIEF.md
# SDRAM Command Decoder with Byte-Lane Masking

This block is the pin-facing front end of a behavioural model of a low-power single-data-rate SDRAM. At every rising clock edge it samples the chip select, the three strobe pins (row strobe, column strobe, write enable), the clock enable, the two bank bits, the twelve address bits and the byte-mask pins. From these it forms one registered command strobe with a command code and the fields the memory core needs: bank, row, column, auto-precharge and precharge-all. It also holds the mode register and the extended mode register, and it flags mode-register loads that carry a reserved bank code.

The byte-mask pins drive two paths with different timing. Write lane enables follow the mask with no delay, so they gate the data that the same edge captures. Read output enables are delayed by two clocks, so a mask applied with a read burst in progress blanks the matching data beat. The data width is a build parameter: 16-bit (two lanes, 9-bit column) or 32-bit (four lanes, 8-bit column). The array, refresh timing, burst counting and bank timing checks belong to other blocks.

Top module: `sdcmd_front`

## Requirements
- R1: With cs_n high at an edge, cmd_vld is 0 after that edge and neither mode register changes. Commands already in progress elsewhere are unaffected.
- R2: With cs_n low and cke high, the pins {ras_n,cas_n,we_n} decode as follows: 111 NOP (code 0), 011 ACTIVE (1), 101 READ (2), 100 WRITE (3), 110 BURST STOP (4), 010 PRECHARGE (5), 001 AUTO REFRESH (6), 000 LOAD MODE (8). Code 7 is SELF REFRESH. Outputs are registered and appear after the sampling edge. Any field that does not apply to the decoded command is 0, and cmd_code is 0 whenever cmd_vld is 0.
- R3: ACTIVE puts addr[11:0] on cmd_row and ba on cmd_bank.
- R4: READ and WRITE put addr[COL_W-1:0] on cmd_col (COL_W is 9 for 16-bit, 8 for 32-bit), put ba on cmd_bank, and set cmd_ap to addr[10].
- R5: For PRECHARGE with addr[10]=0, cmd_bank is ba and cmd_pall is 0. With addr[10]=1, cmd_pall is 1 and cmd_bank is 0 whatever ba is.
- R6: The refresh encoding with cke high gives AUTO REFRESH (code 6) with bank, row, column and flag fields all 0 for any address.
- R7: With cke low, the refresh encoding gives SELF REFRESH (code 7) with zero fields. Every other encoding gives cmd_vld 0.
- R8: LOAD MODE with ba=00 loads addr[10:0] into mr_val. With ba=10 it loads addr[10:0] into emr_val. Either value is visible after the sampling edge.
- R9: LOAD MODE with ba=01 or ba=11 leaves both registers unchanged and sets mr_err. mr_err stays set until reset.
- R10: wr_lane_en[i] is the inverse of dqm[i] in the same cycle, with no register. wr_bit_en[8i+7:8i] copies wr_lane_en[i]. In 32-bit mode lanes 0 to 3 cover the bytes in ascending order.
- R11: rd_lane_oe is the inverse of the dqm value sampled two edges earlier: dqm sampled at edge k governs rd_lane_oe from edge k+1 to edge k+2. rd_bit_oe expands it per byte in the same way as wr_bit_en.
- R12: BURST STOP decodes as code 4, distinct from PRECHARGE, with all fields 0.
- R13: During reset every registered output is 0, including rd_lane_oe (all lanes disabled).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Device clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable strobe, active low |
| cke | input | 1 | Clock enable |
| ba | input | 2 | Bank address |
| addr | input | 12 | Address bus |
| dqm | input | MASK_W | Byte masks, 1 = masked |
| cmd_vld | output | 1 | Decoded command strobe |
| cmd_code | output | 4 | Command code |
| cmd_bank | output | 2 | Bank field |
| cmd_row | output | 12 | Row field |
| cmd_col | output | COL_W | Column field |
| cmd_ap | output | 1 | Auto-precharge request |
| cmd_pall | output | 1 | Precharge all banks |
| mr_val | output | 11 | Mode register |
| emr_val | output | 11 | Extended mode register |
| mr_err | output | 1 | Sticky reserved-target flag |
| wr_lane_en | output | MASK_W | Write enable per lane |
| wr_bit_en | output | 8*MASK_W | Write enable per data bit |
| rd_lane_oe | output | MASK_W | Read output enable per lane |
| rd_bit_oe | output | 8*MASK_W | Read output enable per data bit |

## Verification
Two situations are hard to reach from the ports. The first is a mode-register load with a reserved bank code that follows a valid load: it shows that the flag sets while both registers keep their earlier values, so the stimulus places directed loads around the reserved ones. The second is the refresh encoding with cke low, mixed with other encodings under cke low. Random stimulus drops cke often enough to reach it, and a directed vector forces it. The two-clock read-mask delay is checked on every vector against the mask from the vector before, so mask changes on consecutive cycles are covered by the random stream.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;

  typedef enum logic [3:0] {
    C_NOP   = 4'd0,
    C_ACT   = 4'd1,
    C_READ  = 4'd2,
    C_WRITE = 4'd3,
    C_BSTOP = 4'd4,
    C_PRE   = 4'd5,
    C_AREF  = 4'd6,
    C_SREF  = 4'd7,
    C_LMR   = 4'd8
  } cmd_e;

  typedef struct packed {
    logic vld;
    cmd_e code;
  } dec_t;

  // number of byte lanes for the chosen data width
  function automatic int lane_count(input bit wide32);
    return wide32 ? 4 : 2;
  endfunction

  // column address width for the chosen data width
  function automatic int col_width(input bit wide32);
    return wide32 ? 8 : 9;
  endfunction

  // strobe pattern to command, chip select handled by the caller
  function automatic dec_t classify(input logic ras_n, input logic cas_n,
                                    input logic we_n, input logic cke);
    dec_t d;
    logic [2:0] p;
    p = {ras_n, cas_n, we_n};
    d.vld  = 1'b1;
    d.code = C_NOP;
    if (!cke) begin
      if (p == 3'b001) d.code = C_SREF;
      else d.vld = 1'b0;
    end else begin
      case (p)
        3'b111:  d.code = C_NOP;
        3'b011:  d.code = C_ACT;
        3'b101:  d.code = C_READ;
        3'b100:  d.code = C_WRITE;
        3'b110:  d.code = C_BSTOP;
        3'b010:  d.code = C_PRE;
        3'b001:  d.code = C_AREF;
        default: d.code = C_LMR;
      endcase
    end
    return d;
  endfunction

endpackage

// File: rtl/sdcmd_decode.sv
module sdcmd_decode
  import sdcmd_pkg::*;
#(
  parameter int COL_W = 9,
  parameter int ROW_W = 12,
  parameter int BA_W  = 2,
  parameter int AP_BIT = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             ras_n,
  input  logic             cas_n,
  input  logic             we_n,
  input  logic             cke,
  input  logic [BA_W-1:0]  ba,
  input  logic [ROW_W-1:0] addr,
  output logic             lmr_now,
  output logic             cmd_vld,
  output cmd_e             cmd_code,
  output logic [BA_W-1:0]  cmd_bank,
  output logic [ROW_W-1:0] cmd_row,
  output logic [COL_W-1:0] cmd_col,
  output logic             cmd_ap,
  output logic             cmd_pall
);

  dec_t             dec;
  logic             hit;
  cmd_e             code_n;
  logic             is_rw;
  logic             bank_used;
  logic [BA_W-1:0]  bank_n;
  logic [ROW_W-1:0] row_n;
  logic [COL_W-1:0] col_n;
  logic             ap_n;
  logic             pall_n;

  always_comb begin
    dec       = classify(ras_n, cas_n, we_n, cke);
    hit       = !cs_n && dec.vld;
    code_n    = hit ? dec.code : C_NOP;
    is_rw     = hit && (code_n == C_READ || code_n == C_WRITE);
    bank_used = hit && (code_n == C_ACT || is_rw ||
                        (code_n == C_PRE && !addr[AP_BIT]));
    bank_n    = bank_used ? ba : '0;
    row_n     = (hit && code_n == C_ACT) ? addr : '0;
    col_n     = is_rw ? addr[COL_W-1:0] : '0;
    ap_n      = is_rw && addr[AP_BIT];
    pall_n    = hit && code_n == C_PRE && addr[AP_BIT];
    lmr_now   = hit && code_n == C_LMR;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_vld  <= 1'b0;
      cmd_code <= C_NOP;
      cmd_bank <= '0;
      cmd_row  <= '0;
      cmd_col  <= '0;
      cmd_ap   <= 1'b0;
      cmd_pall <= 1'b0;
    end else begin
      cmd_vld  <= hit;
      cmd_code <= code_n;
      cmd_bank <= bank_n;
      cmd_row  <= row_n;
      cmd_col  <= col_n;
      cmd_ap   <= ap_n;
      cmd_pall <= pall_n;
    end
  end

  // R1: a deselected cycle never produces a strobe
  p_inhibit_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cs_n) |-> !cmd_vld);

  // R7: with cke low only self refresh can come out
  p_cke_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(cke) && cmd_vld) |-> cmd_code == C_SREF);

  // R5: precharge-all always reports bank zero on a precharge
  p_pall_bank_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_pall |-> (cmd_code == C_PRE && cmd_bank == '0));

  // R4: a column or auto-precharge only accompanies an access
  p_col_only_rw_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_col != '0 || cmd_ap) |-> (cmd_code == C_READ || cmd_code == C_WRITE));

endmodule

// File: rtl/sdcmd_modereg.sv
module sdcmd_modereg #(
  parameter int OP_W = 11,
  parameter int BA_W = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            lmr_now,
  input  logic [BA_W-1:0] ba,
  input  logic [OP_W-1:0] op,
  output logic [OP_W-1:0] mr_val,
  output logic [OP_W-1:0] emr_val,
  output logic            mr_err
);

  logic wr_mr;
  logic wr_emr;
  logic lmr_rsvd;

  always_comb begin
    wr_mr    = lmr_now && ba == 2'b00;
    wr_emr   = lmr_now && ba == 2'b10;
    lmr_rsvd = lmr_now && ba[0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mr_val  <= '0;
      emr_val <= '0;
      mr_err  <= 1'b0;
    end else begin
      if (wr_mr)    mr_val  <= op;
      if (wr_emr)   emr_val <= op;
      if (lmr_rsvd) mr_err  <= 1'b1;
    end
  end

  // R8: a load of the base register lands on the next edge
  p_mr_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_mr |=> mr_val == $past(op));

  // R9: a reserved target touches neither register
  p_rsvd_keeps_r9: assert property (@(posedge clk) disable iff (!rst_n)
    lmr_rsvd |=> ($stable(mr_val) && $stable(emr_val)));

  // R9: the error flag never clears outside reset
  p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mr_err |=> mr_err);

endmodule

// File: rtl/sdcmd_dqm_path.sv
module sdcmd_dqm_path #(
  parameter int MASK_W = 2,
  parameter int LANE_BITS = 8,
  localparam int DQ_W = MASK_W * LANE_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MASK_W-1:0] dqm,
  output logic [MASK_W-1:0] wr_lane_en,
  output logic [DQ_W-1:0]   wr_bit_en,
  output logic [MASK_W-1:0] rd_lane_oe,
  output logic [DQ_W-1:0]   rd_bit_oe
);

  logic [MASK_W-1:0] rd_stage1;
  logic [1:0]        warm;

  for (genvar i = 0; i < MASK_W; i++) begin : g_lane
    assign wr_lane_en[i] = ~dqm[i];
    assign wr_bit_en[i*LANE_BITS +: LANE_BITS] = {LANE_BITS{wr_lane_en[i]}};
    assign rd_bit_oe[i*LANE_BITS +: LANE_BITS] = {LANE_BITS{rd_lane_oe[i]}};

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        rd_stage1[i]  <= 1'b0;
        rd_lane_oe[i] <= 1'b0;
      end else begin
        rd_stage1[i]  <= ~dqm[i];
        rd_lane_oe[i] <= rd_stage1[i];
      end
    end
  end

  // edges since reset, saturating, gates the delay check
  always_ff @(posedge clk) begin
    if (!rst_n) warm <= 2'd0;
    else if (warm != 2'd2) warm <= warm + 2'd1;
  end

  // R11: read enable follows the mask two samples back
  p_rd_delay_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (warm == 2'd2) |-> rd_lane_oe == ~$past(dqm, 2));

  // R13: read path stays disabled on the first edge after reset
  p_rd_reset_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (warm == 2'd0) |-> rd_lane_oe == '0);

endmodule

// File: rtl/sdcmd_front.sv
module sdcmd_front
  import sdcmd_pkg::*;
#(
  parameter bit WIDE32 = 1'b0,
  localparam int MASK_W = lane_count(WIDE32),
  localparam int COL_W  = col_width(WIDE32),
  localparam int DQ_W   = MASK_W * 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic              cke,
  input  logic [1:0]        ba,
  input  logic [11:0]       addr,
  input  logic [MASK_W-1:0] dqm,
  output logic              cmd_vld,
  output logic [3:0]        cmd_code,
  output logic [1:0]        cmd_bank,
  output logic [11:0]       cmd_row,
  output logic [COL_W-1:0]  cmd_col,
  output logic              cmd_ap,
  output logic              cmd_pall,
  output logic [10:0]       mr_val,
  output logic [10:0]       emr_val,
  output logic              mr_err,
  output logic [MASK_W-1:0] wr_lane_en,
  output logic [DQ_W-1:0]   wr_bit_en,
  output logic [MASK_W-1:0] rd_lane_oe,
  output logic [DQ_W-1:0]   rd_bit_oe
);

  logic lmr_now;
  cmd_e code_q;

  sdcmd_decode #(.COL_W(COL_W), .ROW_W(12), .BA_W(2), .AP_BIT(10)) u_dec (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .cke(cke), .ba(ba), .addr(addr), .lmr_now(lmr_now),
    .cmd_vld(cmd_vld), .cmd_code(code_q), .cmd_bank(cmd_bank),
    .cmd_row(cmd_row), .cmd_col(cmd_col), .cmd_ap(cmd_ap), .cmd_pall(cmd_pall)
  );

  assign cmd_code = code_q;

  sdcmd_modereg #(.OP_W(11), .BA_W(2)) u_mr (
    .clk(clk), .rst_n(rst_n), .lmr_now(lmr_now), .ba(ba), .op(addr[10:0]),
    .mr_val(mr_val), .emr_val(emr_val), .mr_err(mr_err)
  );

  sdcmd_dqm_path #(.MASK_W(MASK_W), .LANE_BITS(8)) u_dqm (
    .clk(clk), .rst_n(rst_n), .dqm(dqm), .wr_lane_en(wr_lane_en),
    .wr_bit_en(wr_bit_en), .rd_lane_oe(rd_lane_oe), .rd_bit_oe(rd_bit_oe)
  );

  // R2: code is zero whenever no command was decoded
  p_idle_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_vld |-> cmd_code == 4'd0);

  // R1: a deselected cycle leaves both mode registers untouched
  p_inhibit_mr_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> ($stable(mr_val) && $stable(emr_val)));

endmodule

// File: tb/sdcmd_front_test.sv
`timescale 1ns/1ps
module sdcmd_front_test;
  localparam int MW = 2;
  localparam int CW = 9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, cke = 1'b1;
  logic [1:0] ba = '0;
  logic [11:0] addr = '0;
  logic [MW-1:0] dqm = '1;
  logic cmd_vld, cmd_ap, cmd_pall, mr_err;
  logic [3:0] cmd_code;
  logic [1:0] cmd_bank;
  logic [11:0] cmd_row;
  logic [CW-1:0] cmd_col;
  logic [10:0] mr_val, emr_val;
  logic [MW-1:0] wr_lane_en, rd_lane_oe;
  logic [8*MW-1:0] wr_bit_en, rd_bit_oe;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // expected values for the outputs after the next edge
  logic e_vld, e_ap, e_pall, e_err;
  logic [3:0] e_code;
  logic [1:0] e_bank;
  logic [11:0] e_row;
  logic [CW-1:0] e_col;
  logic [10:0] e_mr, e_emr;
  logic [MW-1:0] e_rd, prev_dqm;

  always #2.5 clk = ~clk;

  sdcmd_front #(.WIDE32(1'b0)) uut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .cke(cke), .ba(ba), .addr(addr), .dqm(dqm),
    .cmd_vld(cmd_vld), .cmd_code(cmd_code), .cmd_bank(cmd_bank),
    .cmd_row(cmd_row), .cmd_col(cmd_col), .cmd_ap(cmd_ap), .cmd_pall(cmd_pall),
    .mr_val(mr_val), .emr_val(emr_val), .mr_err(mr_err),
    .wr_lane_en(wr_lane_en), .wr_bit_en(wr_bit_en),
    .rd_lane_oe(rd_lane_oe), .rd_bit_oe(rd_bit_oe)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // table of the command encodings, written out per pin pattern
  function automatic logic [4:0] model_cmd(input logic c, r, a, w, k);
    if (c) return 5'h00;
    if (!k) return ({r, a, w} == 3'b001) ? 5'h17 : 5'h00;
    unique case ({r, a, w})
      3'b111: return 5'h10;
      3'b011: return 5'h11;
      3'b101: return 5'h12;
      3'b100: return 5'h13;
      3'b110: return 5'h14;
      3'b010: return 5'h15;
      3'b001: return 5'h16;
      default: return 5'h18;
    endcase
  endfunction

  function automatic logic [MW*8-1:0] spread(input logic [MW-1:0] l);
    logic [MW*8-1:0] v;
    for (int i = 0; i < MW; i++) v[i*8 +: 8] = l[i] ? 8'hFF : 8'h00;
    return v;
  endfunction

  task automatic check_regs();
    string tag;
    tag = (e_code == 4'd1) ? "R3" : (e_code == 4'd2 || e_code == 4'd3) ? "R4" :
          (e_code == 4'd5) ? "R5" : (e_code == 4'd6) ? "R6" :
          (e_code == 4'd7) ? "R7" : (e_code == 4'd4) ? "R12" :
          e_vld ? "R2" : "R1";
    chk(tag, "vld",  {31'b0, cmd_vld}, {31'b0, e_vld});
    chk(tag, "code", {28'b0, cmd_code}, {28'b0, e_code});
    chk(tag, "fields", {cmd_bank, cmd_row, cmd_col, cmd_ap, cmd_pall},
                       {e_bank, e_row, e_col, e_ap, e_pall});
    chk("R8", "mode regs", {mr_val, emr_val}, {e_mr, e_emr});
    chk("R9", "mr_err", {31'b0, mr_err}, {31'b0, e_err});
    chk("R11", "rd oe", {rd_bit_oe, rd_lane_oe}, {spread(e_rd), e_rd});
  endtask

  task automatic apply(input logic c, r, a, w, k, input logic [1:0] b,
                       input logic [11:0] ad, input logic [MW-1:0] m);
    logic [4:0] d;
    @(negedge clk);
    check_regs();
    cs_n = c; ras_n = r; cas_n = a; we_n = w; cke = k; ba = b; addr = ad; dqm = m;
    #0.5;
    chk("R10", "wr en", {wr_bit_en, wr_lane_en}, {spread(~m), ~m});
    d = model_cmd(c, r, a, w, k);
    e_vld = d[4]; e_code = d[3:0];
    e_bank = '0; e_row = '0; e_col = '0; e_ap = 1'b0; e_pall = 1'b0;
    if (e_code == 4'd1) begin e_row = ad; e_bank = b; end
    if (e_code == 4'd2 || e_code == 4'd3) begin
      e_col = ad[CW-1:0]; e_bank = b; e_ap = ad[10];
    end
    if (e_code == 4'd5) begin
      if (ad[10]) e_pall = 1'b1; else e_bank = b;
    end
    if (e_code == 4'd8) begin
      if (b == 2'b00) e_mr = ad[10:0];
      else if (b == 2'b10) e_emr = ad[10:0];
      else e_err = 1'b1;
    end
    e_rd = ~prev_dqm;
    prev_dqm = m;
  endtask

  initial begin
    e_vld = 0; e_code = 0; e_bank = 0; e_row = 0; e_col = 0; e_ap = 0;
    e_pall = 0; e_err = 0; e_mr = 0; e_emr = 0; e_rd = 0; prev_dqm = '1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R13", "reset vld/code", {27'b0, cmd_vld, cmd_code}, 32'h0);
    chk("R13", "reset regs", {21'b0, mr_val}, 32'h0);
    chk("R13", "reset err/rd", {29'b0, mr_err, rd_lane_oe}, 32'h0);
    rst_n = 1'b1;
    // directed corner cases
    apply(0, 0, 0, 0, 1, 2'b00, 12'h5A5, 2'b00); // R8 base load
    apply(0, 0, 0, 0, 1, 2'b10, 12'h3C3, 2'b01); // R8 extended load
    apply(0, 0, 0, 0, 1, 2'b01, 12'h7FF, 2'b10); // R9 reserved
    apply(0, 0, 0, 0, 1, 2'b11, 12'h000, 2'b11); // R9 reserved
    apply(1, 0, 0, 0, 1, 2'b00, 12'h111, 2'b00); // R1 inhibited load
    apply(0, 1, 1, 0, 1, 2'b11, 12'hFFF, 2'b01); // R12 burst stop
    apply(0, 0, 1, 0, 1, 2'b11, 12'h400, 2'b10); // R5 precharge all
    apply(0, 0, 1, 0, 1, 2'b10, 12'hBFF, 2'b00); // R5 single bank
    apply(0, 1, 0, 1, 1, 2'b01, 12'h5FF, 2'b11); // R4 read with ap
    apply(0, 1, 0, 0, 1, 2'b10, 12'hABC, 2'b01); // R4 write no ap
    apply(0, 0, 1, 1, 1, 2'b11, 12'hFED, 2'b10); // R3 activate
    apply(0, 0, 0, 1, 1, 2'b11, 12'hFFF, 2'b00); // R6 auto refresh
    apply(0, 0, 0, 1, 0, 2'b01, 12'h123, 2'b11); // R7 self refresh
    apply(0, 1, 0, 1, 0, 2'b01, 12'h123, 2'b00); // R7 read under cke low
    // constrained random stream, fixed seed
    void'($urandom(32'd1789));
    for (int i = 0; i < 600; i++) begin
      logic c, k;
      logic [2:0] p;
      c = ($urandom % 6) == 0;
      k = ($urandom % 7) != 0;
      p = 3'($urandom);
      apply(c, p[2], p[1], p[0], k, 2'($urandom), 12'($urandom), MW'($urandom));
    end
    @(negedge clk);
    check_regs();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule